// File: doc/BRIEF.md
# Multi-Requester APB Write Arbiter

This block lets several APB requesters share one APB completer for write transfers. Requesters that raise select compete in a fixed index order. The winner holds the grant until its transfer has ended. The block captures the winner's write flag, address, write data, byte strobes and the parity bits for data and strobes into registers and replays them on the completer side as a normal setup phase followed by an access phase. The completer's ready is registered and returned only to the granted requester.

A requester must raise enable in the cycle right after it is granted. If it does not, the block drops that grant without starting anything on the completer side, and the requester loses its place in the order. A requester that has lost its place is then served only when no requester with full priority is asking. It regains full priority once it completes a transfer. A parameter can add one more register stage on the ready return path.

Top module: `apb_wr_arb`

## Requirements
- R1: After reset, every requester ready output is low and completer select and enable are low.
- R2: When several requesters raise select in the same cycle and none has lost priority, the lowest index is served first.
- R3: Completer select rises in the second cycle after the cycle in which the granted requester first raised select. Completer enable is low in that first cycle and rises one cycle later.
- R4: While completer select is high, the completer write flag, address, data, strobes, per-byte data parity (bit k covers data byte k) and strobe parity equal the values the granted requester presented. All of them appear in the same cycle.
- R5: While completer enable is high and completer ready is low, completer enable and every forwarded field stay unchanged, and no requester ready is raised.
- R6: A completer ready seen while completer enable is high ends the access. Completer select and enable drop at the next edge, and the granted requester's ready is high for exactly one cycle, one cycle after the completer's ready (with the default of no extra stage).
- R7: A requester that is not granted sees its ready low. A grant is kept until its transfer has ended, even if other requesters are waiting, and waiting requesters are served afterwards.
- R8: If the granted requester's enable is low in the cycle after the grant, no completer transfer starts. That requester then ranks below every requester that still has full priority.
- R9: A requester that lost priority gets it back when one of its transfers completes.
- R10: With the extra ready stage enabled, the requester's ready comes one cycle later than with it disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_sel_i | input | N_REQ | Select, one bit per requester |
| req_en_i | input | N_REQ | Enable, one bit per requester |
| req_write_i | input | N_REQ | Write flag, one bit per requester |
| req_addr_i | input | N_REQ*ADDR_W | Addresses, requester r at bits r*ADDR_W upward |
| req_wdata_i | input | N_REQ*DATA_W | Write data, packed per requester |
| req_wdata_par_i | input | N_REQ*STRB_W | Per-byte write-data parity, packed per requester |
| req_strb_i | input | N_REQ*STRB_W | Byte strobes, packed per requester |
| req_strb_par_i | input | N_REQ | Strobe parity, one bit per requester |
| req_ready_o | output | N_REQ | Ready returned to each requester |
| cmp_sel_o | output | 1 | Completer select |
| cmp_en_o | output | 1 | Completer enable |
| cmp_write_o | output | 1 | Completer write flag |
| cmp_addr_o | output | ADDR_W | Completer address |
| cmp_wdata_o | output | DATA_W | Completer write data |
| cmp_wdata_par_o | output | STRB_W | Completer per-byte data parity |
| cmp_strb_o | output | STRB_W | Completer byte strobes |
| cmp_strb_par_o | output | 1 | Completer strobe parity |
| cmp_ready_i | input | 1 | Completer ready |

## Verification
The bench goes after arbitration order under simultaneous requests and after the demotion that follows a missing enable. A design with a reversed order, one that forgets demotion, or one that never clears it would forward the wrong requester's address first. It runs wait states of different lengths, where a design that samples ready outside the access phase, or reloads its payload, would end early or change fields mid-access. It also checks that ready is a single-cycle pulse and goes only to the granted requester, so an off-by-one on either path, or a ready sent to a waiting requester, shows up. A second instance with the extra ready stage confirms the one-cycle shift.

// File: rtl/apb_wr_arb_pkg.sv
package apb_wr_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_SETUP,
    ST_ACCESS,
    ST_RESP
  } arb_st_e;
endpackage

// File: rtl/apb_wr_arb_pick.sv
module apb_wr_arb_pick #(
  parameter int unsigned N_REQ = 2
) (
  input  logic [N_REQ-1:0] cand_i,
  input  logic [N_REQ-1:0] demote_i,
  output logic [N_REQ-1:0] gnt_o,
  output logic             any_o
);
  logic [N_REQ-1:0] hi;
  logic [N_REQ-1:0] src;

  // full-priority requesters first, demoted ones only if none of those ask
  assign hi    = cand_i & ~demote_i;
  assign src   = (|hi) ? hi : cand_i;
  assign gnt_o = src & (~src + N_REQ'(1));
  assign any_o = |cand_i;
endmodule

// File: rtl/apb_wr_arb_fwd.sv
module apb_wr_arb_fwd #(
  parameter int unsigned N_REQ  = 2,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STRB_W = 4,
  parameter int unsigned IDX_W  = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [N_REQ-1:0]        write_i,
  input  logic [N_REQ*ADDR_W-1:0] addr_i,
  input  logic [N_REQ*DATA_W-1:0] wdata_i,
  input  logic [N_REQ*STRB_W-1:0] wpar_i,
  input  logic [N_REQ*STRB_W-1:0] strb_i,
  input  logic [N_REQ-1:0]        spar_i,
  output logic                    write_o,
  output logic [ADDR_W-1:0]       addr_o,
  output logic [DATA_W-1:0]       wdata_o,
  output logic [STRB_W-1:0]       wpar_o,
  output logic [STRB_W-1:0]       strb_o,
  output logic                    spar_o
);
  logic [ADDR_W-1:0] addr_a  [N_REQ];
  logic [DATA_W-1:0] wdata_a [N_REQ];
  logic [STRB_W-1:0] wpar_a  [N_REQ];
  logic [STRB_W-1:0] strb_a  [N_REQ];

  for (genvar gi = 0; gi < N_REQ; gi++) begin : g_unpack
    assign addr_a[gi]  = addr_i[gi*ADDR_W +: ADDR_W];
    assign wdata_a[gi] = wdata_i[gi*DATA_W +: DATA_W];
    assign wpar_a[gi]  = wpar_i[gi*STRB_W +: STRB_W];
    assign strb_a[gi]  = strb_i[gi*STRB_W +: STRB_W];
  end

  // parity is captured in the same register stage as the payload it covers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_o <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      wpar_o  <= '0;
      strb_o  <= '0;
      spar_o  <= 1'b0;
    end else if (load_i) begin
      write_o <= write_i[idx_i];
      addr_o  <= addr_a[idx_i];
      wdata_o <= wdata_a[idx_i];
      wpar_o  <= wpar_a[idx_i];
      strb_o  <= strb_a[idx_i];
      spar_o  <= spar_i[idx_i];
    end
  end
endmodule

// File: rtl/apb_wr_arb_rsp.sv
module apb_wr_arb_rsp #(
  parameter int unsigned N_REQ = 2,
  parameter int unsigned EXTRA = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [N_REQ-1:0] gnt_i,
  output logic             done_o,
  output logic [N_REQ-1:0] ready_o
);
  logic [EXTRA:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= 1'b0;
    else         pipe_q[0] <= fire_i;
  end

  if (EXTRA > 0) begin : g_extra
    for (genvar k = 1; k <= EXTRA; k++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[k] <= 1'b0;
        else         pipe_q[k] <= pipe_q[k-1];
      end
    end
  end

  assign done_o  = pipe_q[EXTRA];
  assign ready_o = gnt_i & {N_REQ{done_o}};
endmodule

// File: rtl/apb_wr_arb.sv
module apb_wr_arb
  import apb_wr_arb_pkg::*;
#(
  parameter int unsigned N_REQ           = 2,
  parameter int unsigned ADDR_W          = 32,
  parameter int unsigned DATA_W          = 32,
  parameter int unsigned STRB_W          = DATA_W / 8,
  parameter int unsigned EXTRA_RSP_STAGE = 0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_REQ-1:0]        req_sel_i,
  input  logic [N_REQ-1:0]        req_en_i,
  input  logic [N_REQ-1:0]        req_write_i,
  input  logic [N_REQ*ADDR_W-1:0] req_addr_i,
  input  logic [N_REQ*DATA_W-1:0] req_wdata_i,
  input  logic [N_REQ*STRB_W-1:0] req_wdata_par_i,
  input  logic [N_REQ*STRB_W-1:0] req_strb_i,
  input  logic [N_REQ-1:0]        req_strb_par_i,
  output logic [N_REQ-1:0]        req_ready_o,
  output logic                    cmp_sel_o,
  output logic                    cmp_en_o,
  output logic                    cmp_write_o,
  output logic [ADDR_W-1:0]       cmp_addr_o,
  output logic [DATA_W-1:0]       cmp_wdata_o,
  output logic [STRB_W-1:0]       cmp_wdata_par_o,
  output logic [STRB_W-1:0]       cmp_strb_o,
  output logic                    cmp_strb_par_o,
  input  logic                    cmp_ready_i
);
  localparam int unsigned IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  arb_st_e          state_q;
  logic [N_REQ-1:0] gnt_q;
  logic [N_REQ-1:0] demote_q;
  logic [N_REQ-1:0] pick_gnt;
  logic             pick_any;
  logic [IDX_W-1:0] gnt_idx;
  logic             en_ok;
  logic             load;
  logic             fire;
  logic             rsp_done;
  logic             sel_q;
  logic             en_q;

  apb_wr_arb_pick #(.N_REQ(N_REQ)) u_pick (
    .cand_i   (req_sel_i),
    .demote_i (demote_q),
    .gnt_o    (pick_gnt),
    .any_o    (pick_any)
  );

  always_comb begin
    gnt_idx = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (gnt_q[i]) gnt_idx = IDX_W'(i);
    end
  end

  assign en_ok = |(gnt_q & req_en_i);
  assign load  = (state_q == ST_CHECK) && en_ok;
  assign fire  = (state_q == ST_ACCESS) && cmp_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      gnt_q    <= '0;
      demote_q <= '0;
      sel_q    <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (pick_any) begin
            gnt_q   <= pick_gnt;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (en_ok) begin
            sel_q   <= 1'b1;
            state_q <= ST_SETUP;
          end else begin
            // enable missed its slot: drop the grant and demote
            demote_q <= demote_q | gnt_q;
            gnt_q    <= '0;
            state_q  <= ST_IDLE;
          end
        end
        ST_SETUP: begin
          en_q    <= 1'b1;
          state_q <= ST_ACCESS;
        end
        ST_ACCESS: begin
          if (cmp_ready_i) begin
            sel_q   <= 1'b0;
            en_q    <= 1'b0;
            state_q <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_done) begin
            demote_q <= demote_q & ~gnt_q;
            gnt_q    <= '0;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  apb_wr_arb_fwd #(
    .N_REQ (N_REQ),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .STRB_W(STRB_W),
    .IDX_W (IDX_W)
  ) u_fwd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .idx_i   (gnt_idx),
    .write_i (req_write_i),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .wpar_i  (req_wdata_par_i),
    .strb_i  (req_strb_i),
    .spar_i  (req_strb_par_i),
    .write_o (cmp_write_o),
    .addr_o  (cmp_addr_o),
    .wdata_o (cmp_wdata_o),
    .wpar_o  (cmp_wdata_par_o),
    .strb_o  (cmp_strb_o),
    .spar_o  (cmp_strb_par_o)
  );

  apb_wr_arb_rsp #(
    .N_REQ(N_REQ),
    .EXTRA(EXTRA_RSP_STAGE)
  ) u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .gnt_i   (gnt_q),
    .done_o  (rsp_done),
    .ready_o (req_ready_o)
  );

  assign cmp_sel_o = sel_q;
  assign cmp_en_o  = en_q;
endmodule

// File: rtl/apb_wr_arb_chk.sv
module apb_wr_arb_chk #(
  parameter int unsigned N_REQ  = 2,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STRB_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_REQ-1:0]  req_ready_o,
  input logic              cmp_sel_o,
  input logic              cmp_en_o,
  input logic              cmp_write_o,
  input logic [ADDR_W-1:0] cmp_addr_o,
  input logic [DATA_W-1:0] cmp_wdata_o,
  input logic [STRB_W-1:0] cmp_wdata_par_o,
  input logic [STRB_W-1:0] cmp_strb_o,
  input logic              cmp_strb_par_o,
  input logic              cmp_ready_i
);
  p_en_inside_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_en_o |-> cmp_sel_o);

  p_setup_then_access_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmp_sel_o) |-> !cmp_en_o ##1 cmp_en_o);

  p_hold_in_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en_o && !cmp_ready_i) |=> (cmp_en_o && $stable(cmp_addr_o) && $stable(cmp_wdata_o)
      && $stable(cmp_wdata_par_o) && $stable(cmp_strb_o) && $stable(cmp_strb_par_o)
      && $stable(cmp_write_o)));

  p_no_ready_in_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_sel_o |-> (req_ready_o == '0));

  p_close_on_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en_o && cmp_ready_i) |=> (!cmp_sel_o && !cmp_en_o));

  p_ready_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o));

  p_ready_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_ready_o) |=> (req_ready_o == '0));
endmodule

bind apb_wr_arb apb_wr_arb_chk #(
  .N_REQ (N_REQ),
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .STRB_W(STRB_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_ready_o    (req_ready_o),
  .cmp_sel_o      (cmp_sel_o),
  .cmp_en_o       (cmp_en_o),
  .cmp_write_o    (cmp_write_o),
  .cmp_addr_o     (cmp_addr_o),
  .cmp_wdata_o    (cmp_wdata_o),
  .cmp_wdata_par_o(cmp_wdata_par_o),
  .cmp_strb_o     (cmp_strb_o),
  .cmp_strb_par_o (cmp_strb_par_o),
  .cmp_ready_i    (cmp_ready_i)
);

// File: tb/apb_wr_arb_tb.sv
`timescale 1ns/1ps
module apb_wr_arb_tb;
  localparam int N = 2, AW = 32, DW = 32, SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]    sel = '0, en = '0, wr = '0, spar = '0;
  logic [N*AW-1:0] addr = '0;
  logic [N*DW-1:0] wdata = '0;
  logic [N*SW-1:0] wpar = '0, strb = '0;
  logic            cmp_rdy = 1'b1;

  logic [N-1:0]  rdy, rdy_x;
  logic          c_sel, c_en, c_wr, c_spar;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_wdata;
  logic [SW-1:0] c_wpar, c_strb;
  logic          x_sel, x_en, x_wr, x_spar;
  logic [AW-1:0] x_addr;
  logic [DW-1:0] x_wdata;
  logic [SW-1:0] x_wpar, x_strb;

  apb_wr_arb u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_sel_i(sel), .req_en_i(en), .req_write_i(wr), .req_addr_i(addr),
    .req_wdata_i(wdata), .req_wdata_par_i(wpar), .req_strb_i(strb), .req_strb_par_i(spar),
    .req_ready_o(rdy),
    .cmp_sel_o(c_sel), .cmp_en_o(c_en), .cmp_write_o(c_wr), .cmp_addr_o(c_addr),
    .cmp_wdata_o(c_wdata), .cmp_wdata_par_o(c_wpar), .cmp_strb_o(c_strb),
    .cmp_strb_par_o(c_spar), .cmp_ready_i(cmp_rdy)
  );

  apb_wr_arb #(.EXTRA_RSP_STAGE(1)) u_dut_x (
    .clk_i(clk), .rst_ni(rst_n),
    .req_sel_i(sel), .req_en_i(en), .req_write_i(wr), .req_addr_i(addr),
    .req_wdata_i(wdata), .req_wdata_par_i(wpar), .req_strb_i(strb), .req_strb_par_i(spar),
    .req_ready_o(rdy_x),
    .cmp_sel_o(x_sel), .cmp_en_o(x_en), .cmp_write_o(x_wr), .cmp_addr_o(x_addr),
    .cmp_wdata_o(x_wdata), .cmp_wdata_par_o(x_wpar), .cmp_strb_o(x_strb),
    .cmp_strb_par_o(x_spar), .cmp_ready_i(1'b1)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] byte_par(input logic [DW-1:0] d);
    logic [SW-1:0] p;
    for (int b = 0; b < SW; b++) p[b] = ^d[b*8 +: 8];
    return p;
  endfunction

  task automatic load_req(input int r, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [SW-1:0] s);
    addr[r*AW +: AW]  = a;
    wdata[r*DW +: DW] = d;
    strb[r*SW +: SW]  = s;
    wpar[r*SW +: SW]  = byte_par(d);
    spar[r]           = ^s;
    wr[r]             = 1'b1;
  endtask

  task automatic chk_payload(input string tag, input int r);
    chk({tag, " addr"}, 64'(c_addr), 64'(addr[r*AW +: AW]));
    chk({tag, " wdata"}, 64'(c_wdata), 64'(wdata[r*DW +: DW]));
    chk({tag, " strb"}, 64'(c_strb), 64'(strb[r*SW +: SW]));
    chk({tag, " wpar"}, 64'(c_wpar), 64'(byte_par(wdata[r*DW +: DW])));
    chk({tag, " spar"}, 64'(c_spar), 64'(^strb[r*SW +: SW]));
    chk({tag, " write"}, 64'(c_wr), 64'(1));
  endtask

  task automatic drop_req(input int r);
    sel[r] = 1'b0; en[r] = 1'b0; wr[r] = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ready", 64'(rdy), 64'(0));
    chk("R1 sel", 64'(c_sel), 64'(0));
    chk("R1 en", 64'(c_en), 64'(0));
  endtask

  // single requester transfer with a given number of wait states
  task automatic t_xfer(input int r, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [SW-1:0] s, input int waits, input bit chk_x);
    @(negedge clk);
    cmp_rdy = (waits == 0);
    load_req(r, a, d, s);
    sel[r] = 1'b1;
    @(negedge clk);
    chk("R3 sel not yet", 64'(c_sel), 64'(0));
    en[r] = 1'b1;
    @(negedge clk);
    chk("R3 sel rises", 64'(c_sel), 64'(1));
    chk("R3 setup en low", 64'(c_en), 64'(0));
    chk_payload("R4", r);
    @(negedge clk);
    chk("R3 en rises", 64'(c_en), 64'(1));
    for (int k = 0; k < waits; k++) begin
      chk("R5 en held", 64'(c_en), 64'(1));
      chk("R5 no ready", 64'(rdy), 64'(0));
      chk_payload("R5", r);
      @(negedge clk);
    end
    cmp_rdy = 1'b1;
    @(negedge clk);
    chk("R6 ready to owner", 64'(rdy), 64'(1) << r);
    chk("R6 sel dropped", 64'(c_sel), 64'(0));
    chk("R6 en dropped", 64'(c_en), 64'(0));
    if (chk_x) chk("R10 extra stage not yet", 64'(rdy_x[r]), 64'(0));
    drop_req(r);
    @(negedge clk);
    chk("R6 ready one cycle", 64'(rdy), 64'(0));
    if (chk_x) chk("R10 extra stage ready", 64'(rdy_x[r]), 64'(1));
    repeat (4) @(negedge clk);
  endtask

  // wait until requester exp finishes; check whose address reaches the completer first
  task automatic serve(input string tag, input int exp, input int other);
    bit seen = 1'b0;
    bit done = 1'b0;
    for (int n = 0; n < 30 && !done; n++) begin
      @(negedge clk);
      if (c_en && !seen) begin
        chk({tag, " served addr"}, 64'(c_addr), 64'(addr[exp*AW +: AW]));
        seen = 1'b1;
      end
      if (rdy[other]) chk("R7 waiting ready low", 64'(rdy[other]), 64'(0));
      if (rdy[exp]) done = 1'b1;
    end
    chk({tag, " completed"}, 64'(done), 64'(1));
    drop_req(exp);
  endtask

  task automatic t_pair(input string tag, input int first);
    int second = 1 - first;
    @(negedge clk);
    cmp_rdy = 1'b1;
    load_req(0, 32'h0000_1000, 32'hA5A5_0001, 4'hF);
    load_req(1, 32'h0000_2000, 32'h5A5A_0002, 4'h3);
    sel = 2'b11;
    @(negedge clk);
    en = 2'b11;
    serve(tag, first, second);
    serve("R7 held grant", second, first);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_late();
    @(negedge clk);
    load_req(0, 32'h0000_3000, 32'h0BAD_0BAD, 4'h1);
    sel[0] = 1'b1;
    @(negedge clk);
    chk("R8 no sel", 64'(c_sel), 64'(0));
    @(negedge clk);
    chk("R8 no transfer", 64'(c_sel), 64'(0));
    drop_req(0);
    @(negedge clk);
    chk("R8 still idle", 64'(c_sel), 64'(0));
    chk("R8 no ready", 64'(rdy), 64'(0));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_xfer(0, 32'h0000_0040, 32'h1234_5678, 4'hF, 0, 1'b1);
    t_xfer(1, 32'h0000_0080, 32'hFFFF_0000, 4'hC, 0, 1'b0);
    t_xfer(1, 32'h0000_00C0, 32'h8000_0001, 4'h9, 1, 1'b0);
    t_xfer(0, 32'h0000_0100, 32'h0F0F_F0F0, 4'h6, 3, 1'b0);
    t_pair("R2", 0);
    t_late();
    t_pair("R8 demoted", 1);
    t_pair("R9 restored", 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule